// File: doc/BRIEF.md
# Atomic Coefficient Commit Buffer

This block sits between a control port and the parameter memory of an audio processing core. Software uses it to change a small group of coefficients, such as the five terms of one biquad section, so that the core never runs a frame with half of the group updated. The control side fills up to five staging slots. Each slot holds a 28-bit coefficient and the 10-bit parameter-memory address it belongs to. The control side then pulses an arm input. The block waits for the next frame-start strobe from the core and writes every filled slot into parameter memory, one slot position per cycle. This all happens well inside the frame.

The core keeps priority on the single parameter-memory port. In any cycle where the core reads, the read goes to the memory, and a pending commit write for that slot waits one cycle. While the commit runs, the control side is stalled from touching the slots. A busy indication covers the whole span from arming until the last slot position has been handled. Bulk program or parameter downloads do not go through this block. Those are done with the core output halted by a separate control bit, and that path lies outside this block.

Top module: `coef_stage_commit`

## Requirements
- R1: After reset, ctl_busy is 0, ctl_wr_ready is 1, pram_en and pram_we are 0, and every staging slot is empty.
- R2: A cycle with ctl_wr_en and ctl_wr_ready high stores ctl_wr_data and ctl_wr_addr into slot ctl_wr_slot (0 to 4) and marks that slot filled. A later write to the same slot replaces its contents. Slot numbers 5, 6 and 7 are ignored.
- R3: A ctl_arm pulse while idle raises ctl_busy on the next cycle. ctl_arm has no effect while ctl_busy is high.
- R4: A frame_start seen while armed starts the commit in the following cycle. A frame_start in the same cycle as the arm pulse does not start it.
- R5: The commit visits slot positions 0, 1, 2, 3, 4 in that order. A filled slot appears as one cycle with pram_en=1, pram_we=1, pram_addr equal to the slot address and pram_wdata equal to the slot data.
- R6: An empty slot position takes one cycle and causes no memory access.
- R7: When core_rd_en is high, pram_en=1, pram_we=0 and pram_addr=core_rd_addr. A filled slot position in that cycle is retried in the next cycle. An empty slot position still advances.
- R8: ctl_wr_ready is 0 during every commit cycle. A write held by the control side through the commit lands only after the commit ends.
- R9: ctl_busy stays 1 through the last slot position and falls on the next cycle. At that point all slots are empty, so a new commit with no new writes makes no memory writes.
- R10: frame_start has no effect while the block is not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_en | input | 1 | Control write to a staging slot |
| ctl_wr_slot | input | 3 | Target slot number |
| ctl_wr_data | input | 28 | Coefficient value for the slot |
| ctl_wr_addr | input | 10 | Parameter-memory address for the slot |
| ctl_wr_ready | output | 1 | Low while a commit runs (write stalled) |
| ctl_arm | input | 1 | Arm pulse requesting a commit |
| ctl_busy | output | 1 | High from arming to end of commit |
| frame_start | input | 1 | Frame-boundary strobe from the core |
| core_rd_en | input | 1 | Core read request, highest priority |
| core_rd_addr | input | 10 | Core read address |
| pram_en | output | 1 | Parameter memory access enable |
| pram_we | output | 1 | Parameter memory write enable |
| pram_addr | output | 10 | Parameter memory address |
| pram_wdata | output | 28 | Parameter memory write data |

## Verification
The key collision is a core read that arrives in the same cycle as a commit write to a filled slot. The same read can also arrive on an empty slot position, or on the first and last positions. Table rows move the core read across every commit cycle for several slot-fill patterns. A bench model then predicts, cycle by cycle, whether the port shows the read, the slot write, or nothing, and when the commit ends. A second overlap, a control write held through a running commit, is checked by showing that it lands only in the following commit.

// File: rtl/cs_pkg.sv
`timescale 1ns/1ps
package cs_pkg;
    localparam int unsigned CS_SLOTS  = 5;
    localparam int unsigned CS_DATA_W = 28;
    localparam int unsigned CS_ADDR_W = 10;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_ARMED  = 2'd1,
        SEQ_COMMIT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/cs_slot_bank.sv
`timescale 1ns/1ps
module cs_slot_bank #(
    parameter int unsigned SLOTS  = cs_pkg::CS_SLOTS,
    parameter int unsigned DATA_W = cs_pkg::CS_DATA_W,
    parameter int unsigned ADDR_W = cs_pkg::CS_ADDR_W,
    parameter int unsigned IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              clear_all,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [SLOTS-1:0]  valid_vec
);
    typedef struct packed {
        logic [SLOTS-1:0]             valid;
        logic [SLOTS-1:0][DATA_W-1:0] data;
        logic [SLOTS-1:0][ADDR_W-1:0] addr;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [SLOTS-1:0] hit_w;

    // one decoder per slot; numbers past the last slot match nothing
    for (genvar g = 0; g < SLOTS; g++) begin : g_hit
        assign hit_w[g] = wr_en && (wr_idx == IDX_W'(g));
    end

    always_comb begin
        bank_d = bank_q;
        if (clear_all) begin
            bank_d.valid = '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (hit_w[i]) begin
                    bank_d.valid[i] = 1'b1;
                    bank_d.data[i]  = wr_data;
                    bank_d.addr[i]  = wr_addr;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        rd_addr  = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_valid = bank_q.valid[i];
                rd_data  = bank_q.data[i];
                rd_addr  = bank_q.addr[i];
            end
        end
    end

    assign valid_vec = bank_q.valid;

    // R2: an accepted write leaves its slot filled
    a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear_all && (32'(wr_idx) < SLOTS)) |=> valid_vec[$past(wr_idx)]);
endmodule

// File: rtl/cs_commit_seq.sv
`timescale 1ns/1ps
module cs_commit_seq #(
    parameter int unsigned SLOTS = cs_pkg::CS_SLOTS,
    parameter int unsigned IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             frame_start,
    input  logic             slot_valid,
    input  logic             port_free,
    output logic             busy,
    output logic             committing,
    output logic [IDX_W-1:0] idx,
    output logic             fire,
    output logic             clear_all
);
    import cs_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t seq_d, seq_q;
    logic advance;

    always_comb begin
        seq_d     = seq_q;
        fire      = 1'b0;
        clear_all = 1'b0;
        advance   = 1'b0;
        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (arm) seq_d.st = SEQ_ARMED;
            end
            SEQ_ARMED: begin
                if (frame_start) begin
                    seq_d.st  = SEQ_COMMIT;
                    seq_d.idx = '0;
                end
            end
            SEQ_COMMIT: begin
                fire    = slot_valid && port_free;
                advance = !slot_valid || port_free;
                if (advance) begin
                    if (seq_q.idx == LAST_IDX) begin
                        seq_d.st  = SEQ_IDLE;
                        seq_d.idx = '0;
                        clear_all = 1'b1;
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end
            end
            default: seq_d = '{st: SEQ_IDLE, idx: '0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{st: SEQ_IDLE, idx: '0};
        else        seq_q <= seq_d;
    end

    assign busy       = (seq_q.st != SEQ_IDLE);
    assign committing = (seq_q.st == SEQ_COMMIT);
    assign idx        = seq_q.idx;

    // R4: a commit only begins right after a frame strobe
    a_r4_start_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(committing) |-> $past(frame_start));
    // R5: the slot position never leaves the slot range
    a_r5_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        committing |-> (32'(idx) < SLOTS));
    // R9: busy only drops after the last slot position
    a_r9_busy_until_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(committing) && ($past(idx) == LAST_IDX)));
endmodule

// File: rtl/cs_ram_arb.sv
`timescale 1ns/1ps
module cs_ram_arb #(
    parameter int unsigned DATA_W = cs_pkg::CS_DATA_W,
    parameter int unsigned ADDR_W = cs_pkg::CS_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_rd_en,
    input  logic [ADDR_W-1:0] core_rd_addr,
    input  logic              cm_req,
    input  logic [ADDR_W-1:0] cm_addr,
    input  logic [DATA_W-1:0] cm_data,
    output logic              cm_grant,
    output logic              pram_en,
    output logic              pram_we,
    output logic [ADDR_W-1:0] pram_addr,
    output logic [DATA_W-1:0] pram_wdata
);
    // the core always wins the single port
    always_comb begin
        cm_grant   = !core_rd_en;
        pram_en    = 1'b0;
        pram_we    = 1'b0;
        pram_addr  = '0;
        pram_wdata = '0;
        if (core_rd_en) begin
            pram_en   = 1'b1;
            pram_addr = core_rd_addr;
        end else if (cm_req) begin
            pram_en    = 1'b1;
            pram_we    = 1'b1;
            pram_addr  = cm_addr;
            pram_wdata = cm_data;
        end
    end

    // R5: every write to the memory comes from a commit request
    a_r5_write_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        pram_we |-> cm_req);
endmodule

// File: rtl/coef_stage_commit.sv
`timescale 1ns/1ps
module coef_stage_commit #(
    parameter int unsigned SLOTS  = cs_pkg::CS_SLOTS,
    parameter int unsigned DATA_W = cs_pkg::CS_DATA_W,
    parameter int unsigned ADDR_W = cs_pkg::CS_ADDR_W,
    localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_en,
    input  logic [IDX_W-1:0]  ctl_wr_slot,
    input  logic [DATA_W-1:0] ctl_wr_data,
    input  logic [ADDR_W-1:0] ctl_wr_addr,
    output logic              ctl_wr_ready,
    input  logic              ctl_arm,
    output logic              ctl_busy,
    input  logic              frame_start,
    input  logic              core_rd_en,
    input  logic [ADDR_W-1:0] core_rd_addr,
    output logic              pram_en,
    output logic              pram_we,
    output logic [ADDR_W-1:0] pram_addr,
    output logic [DATA_W-1:0] pram_wdata
);
    logic              committing_w;
    logic [IDX_W-1:0]  seq_idx_w;
    logic              fire_w;
    logic              clear_w;
    logic              slot_valid_w;
    logic [DATA_W-1:0] slot_data_w;
    logic [ADDR_W-1:0] slot_addr_w;
    logic [SLOTS-1:0]  valid_vec_w;
    logic              cm_req_w;
    logic              grant_w;
    logic              bank_wr_w;

    assign ctl_wr_ready = !committing_w;
    assign bank_wr_w    = ctl_wr_en && ctl_wr_ready;
    assign cm_req_w     = committing_w && slot_valid_w;

    cs_slot_bank #(
        .SLOTS(SLOTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bank_wr_w),
        .wr_idx    (ctl_wr_slot),
        .wr_data   (ctl_wr_data),
        .wr_addr   (ctl_wr_addr),
        .clear_all (clear_w),
        .rd_idx    (seq_idx_w),
        .rd_valid  (slot_valid_w),
        .rd_data   (slot_data_w),
        .rd_addr   (slot_addr_w),
        .valid_vec (valid_vec_w)
    );

    cs_commit_seq #(
        .SLOTS(SLOTS), .IDX_W(IDX_W)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (ctl_arm),
        .frame_start (frame_start),
        .slot_valid  (slot_valid_w),
        .port_free   (grant_w),
        .busy        (ctl_busy),
        .committing  (committing_w),
        .idx         (seq_idx_w),
        .fire        (fire_w),
        .clear_all   (clear_w)
    );

    cs_ram_arb #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) arb_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .core_rd_en   (core_rd_en),
        .core_rd_addr (core_rd_addr),
        .cm_req       (cm_req_w),
        .cm_addr      (slot_addr_w),
        .cm_data      (slot_data_w),
        .cm_grant     (grant_w),
        .pram_en      (pram_en),
        .pram_we      (pram_we),
        .pram_addr    (pram_addr),
        .pram_wdata   (pram_wdata)
    );

    // R5: the sequencer fire and the memory write agree
    a_r5_fire_is_write: assert property (@(posedge clk) disable iff (!rst_n)
        fire_w |-> (pram_we && (pram_addr == slot_addr_w)));
    // R7: a blocked filled slot is retried, not dropped
    a_r7_retry_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rd_en && cm_req_w) |=> (committing_w && $stable(seq_idx_w)));
    // R8: the control side is stalled whenever a commit writes
    a_r8_stall_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        pram_we |-> !ctl_wr_ready);
    // R9: all slots are empty once busy drops
    a_r9_empty_after: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_busy) |-> (valid_vec_w == '0));
endmodule

// File: tb/coef_stage_commit_tb_top.sv
`timescale 1ns/1ps
module coef_stage_commit_tb_top;
    localparam int NS = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [2:0]  ctl_wr_slot = '0;
    logic [27:0] ctl_wr_data = '0;
    logic [9:0]  ctl_wr_addr = '0;
    logic        ctl_wr_ready;
    logic        ctl_arm = 1'b0;
    logic        ctl_busy;
    logic        frame_start = 1'b0;
    logic        core_rd_en = 1'b0;
    logic [9:0]  core_rd_addr = '0;
    logic        pram_en, pram_we;
    logic [9:0]  pram_addr;
    logic [27:0] pram_wdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    coef_stage_commit dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_slot(ctl_wr_slot),
        .ctl_wr_data(ctl_wr_data), .ctl_wr_addr(ctl_wr_addr),
        .ctl_wr_ready(ctl_wr_ready), .ctl_arm(ctl_arm), .ctl_busy(ctl_busy),
        .frame_start(frame_start), .core_rd_en(core_rd_en),
        .core_rd_addr(core_rd_addr), .pram_en(pram_en), .pram_we(pram_we),
        .pram_addr(pram_addr), .pram_wdata(pram_wdata)
    );

    // {core read cycle (7 = none), slot fill mask}
    localparam logic [7:0] VEC [8] = '{
        {3'd7, 5'b11111}, {3'd0, 5'b11111}, {3'd2, 5'b10101}, {3'd1, 5'b01010},
        {3'd4, 5'b10000}, {3'd3, 5'b00100}, {3'd5, 5'b11111}, {3'd0, 5'b00000}
    };

    function automatic logic [27:0] dat_of(int v, int s);
        return 28'h5A00000 + 28'(v * 256) + 28'(s * 17);
    endfunction
    function automatic logic [9:0] adr_of(int v, int s);
        return 10'(64 + v * 8 + s);
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr_slot(int s, logic [27:0] d, logic [9:0] a);
        ctl_wr_en = 1'b1; ctl_wr_slot = 3'(s); ctl_wr_data = d; ctl_wr_addr = a;
        @(negedge clk);
        ctl_wr_en = 1'b0;
    endtask

    task automatic arm_and_frame();
        ctl_arm = 1'b1;
        @(negedge clk);
        ctl_arm = 1'b0;
        #1;
        chk(ctl_busy && !pram_en, "R3", {62'd0, ctl_busy, pram_en}, 64'h2);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    // called at the negedge of commit cycle 0
    task automatic run_commit(logic [4:0] mask, logic [NS-1:0][27:0] ed,
                              logic [NS-1:0][9:0] ea, int rd_at, bit arm_c0);
        int p = 0;
        int c = 0;
        while (p < NS && c < 20) begin
            core_rd_en   = (c == rd_at);
            core_rd_addr = 10'(960 + c);
            ctl_arm      = arm_c0 && (c == 0);
            #1;
            chk(!ctl_wr_ready && ctl_busy, "R8",
                {62'd0, ctl_wr_ready, ctl_busy}, 64'h1);
            if (core_rd_en) begin
                chk(pram_en && !pram_we && pram_addr == core_rd_addr, "R7",
                    {52'd0, pram_en, pram_we, pram_addr}, {52'd0, 2'b10, core_rd_addr});
            end else if (mask[p]) begin
                chk(pram_en && pram_we && pram_addr == ea[p] && pram_wdata == ed[p], "R5",
                    {24'd0, pram_en, pram_we, pram_addr, pram_wdata},
                    {24'd0, 2'b11, ea[p], ed[p]});
            end else begin
                chk(!pram_en, "R6", {63'd0, pram_en}, 64'd0);
            end
            if (!(mask[p] && core_rd_en)) p++;
            @(negedge clk);
            c++;
        end
        core_rd_en = 1'b0;
        ctl_arm    = 1'b0;
        #1;
        chk(!ctl_busy && ctl_wr_ready && !pram_en, "R9",
            {61'd0, ctl_busy, ctl_wr_ready, pram_en}, 64'h2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [NS-1:0][27:0] ed;
        logic [NS-1:0][9:0]  ea;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk(!ctl_busy && ctl_wr_ready && !pram_en && !pram_we, "R1",
            {60'd0, ctl_busy, ctl_wr_ready, pram_en, pram_we}, 64'h4);

        // R10: frame strobe while idle does nothing
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        #1;
        chk(!ctl_busy && !pram_en, "R10", {62'd0, ctl_busy, pram_en}, 64'd0);

        // table walk, R5 R6 R7 R9
        for (int v = 0; v < 8; v++) begin
            for (int s = 0; s < NS; s++) begin
                ed[s] = dat_of(v, s);
                ea[s] = adr_of(v, s);
                if (VEC[v][s]) wr_slot(s, ed[s], ea[s]);
            end
            arm_and_frame();
            run_commit(VEC[v][4:0], ed, ea, int'(VEC[v][7:5]), 1'b0);
        end

        // R4: arm and frame in one cycle does not start a commit
        ed = '0; ea = '0;
        ed[3] = 28'hABCDEF0; ea[3] = 10'h155;
        wr_slot(3, ed[3], ea[3]);
        ctl_arm = 1'b1; frame_start = 1'b1;
        @(negedge clk);
        ctl_arm = 1'b0; frame_start = 1'b0;
        #1;
        chk(ctl_busy && ctl_wr_ready && !pram_en, "R4",
            {61'd0, ctl_busy, ctl_wr_ready, pram_en}, 64'h6);
        @(negedge clk);
        #1;
        chk(ctl_wr_ready && !pram_en, "R4", {62'd0, ctl_wr_ready, pram_en}, 64'h2);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        // R3: arm in commit cycle 0 must be ignored
        run_commit(5'b01000, ed, ea, 7, 1'b1);
        @(negedge clk);
        #1;
        chk(!ctl_busy, "R3", {63'd0, ctl_busy}, 64'd0);

        // R2: slots 5 and 7 ignored, rewrite of slot 2 replaces it
        ed = '0; ea = '0;
        wr_slot(5, 28'h1111111, 10'h011);
        wr_slot(7, 28'h2222222, 10'h022);
        wr_slot(2, 28'h3333333, 10'h033);
        ed[2] = 28'h4444444; ea[2] = 10'h044;
        wr_slot(2, ed[2], ea[2]);
        arm_and_frame();
        run_commit(5'b00100, ed, ea, 7, 1'b0);

        // R9: slots empty after commit, a bare commit writes nothing
        arm_and_frame();
        run_commit(5'b00000, ed, ea, 7, 1'b0);

        // R8: write held through a commit lands only afterwards
        ed = '0; ea = '0;
        ed[0] = 28'h0F0F0F0; ea[0] = 10'h0F0;
        wr_slot(0, ed[0], ea[0]);
        arm_and_frame();
        ctl_wr_en = 1'b1; ctl_wr_slot = 3'd4;
        ctl_wr_data = 28'h7654321; ctl_wr_addr = 10'h2AA;
        run_commit(5'b00001, ed, ea, 7, 1'b0);
        @(negedge clk);
        ctl_wr_en = 1'b0;
        ed = '0; ea = '0;
        ed[4] = 28'h7654321; ea[4] = 10'h2AA;
        arm_and_frame();
        run_commit(5'b10000, ed, ea, 2, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule